// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks feedback and reference divider settings for a clock synthesiser by trying every candidate pair and keeping the one whose output comes closest to a requested pixel clock. The caller gives the desired clock as a period in picoseconds and pulses `start`. The engine converts the period to a frequency in units of 10 kHz and clamps it to the synthesiser's usable range. It then picks a power-of-two post-divide exponent and forms a target with 8 fractional bits. Next it sweeps the two dividers, computing a fixed-point output frequency for each pair. When the sweep is finished it raises `done` for one cycle, and `word` holds the packed 16-bit program word.

A single shared sequential divider does every division: the period conversion, the target scaling and each candidate. One candidate is scored per divider completion. The sweep bounds, the clamp limits and the reference constant are parameters. A bench can therefore run a narrowed sweep while the defaults give the full search.

Top module: `pll_div_search`

## Requirements
- R1: After synchronous reset `busy`, `done` and `word` are all zero.
- R2: A `start` seen while idle makes `busy` high from the next cycle. The search ends with exactly one single-cycle `done` pulse, and `busy` is low in that same cycle.
- R3: The frequency f is floor(100000000 / period_ps). If f is zero the result word is 0x00E0 and no sweep takes place.
- R4: A nonzero f is clamped to the range F_MIN..F_MAX (8000..15938 by default). Periods whose frequencies clamp to the same value give the same word.
- R5: The target is floor(fc * 256 / 100), taken from the clamped frequency fc before any doubling.
- R6: The exponent k starts at 0 and grows by one while fc * 2^k is below 8 * F_MIN. It appears in word bits [7:6].
- R7: The sweep runs M from M_LO to M_HI in the outer loop and N from N_LO to N_HI in the inner loop. Every pair is scored once.
- R8: A candidate's output is floor(938356 * (N + 8) / ((M + 2) * 2^(k+8))), and its error is the absolute difference from the target.
- R9: The best pair is replaced only when the new error is strictly lower than the best so far. The best error starts at all ones, so the first pair with the minimum error in sweep order wins.
- R10: The word is k*64 + M + N*256: M is in bits [5:0], k in bits [7:6] and N in bits [15:8].
- R11: `start` is ignored while `busy` is high. The running search finishes with the word for its own period, and no further `done` follows.
- R12: `word` changes only in a cycle where `done` is high, and holds its value between searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search when idle |
| period_ps | input | 32 | Requested clock period in picoseconds, sampled with start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the word is ready |
| word | output | 16 | Packed program word (exponent, M, N) |

## Verification
Several periods are tried, and each word is compared with a loop in the bench written from the requirements.
- In-range periods exercise the target scaling and the error minimisation.
- Periods above the upper limit, and periods below the lower limit, show whether clamping happens before scaling: pairs of such periods must give identical words.
- Periods of 1e8 ps or more separate the zero-frequency shortcut from clamping to the minimum: a period of exactly 1e8 gives f = 1 and is clamped, while larger periods give the fixed 0x00E0 word.
- A second start issued mid-search, followed by a long idle stretch, shows whether the engine ignores requests while busy and keeps its word stable.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef logic [7:0]  idx_t;
    typedef logic [31:0] val_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FREQ,
        S_SCALE,
        S_EVAL,
        S_PACK
    } pds_state_e;

    localparam logic [15:0] ZERO_FREQ_WORD = 16'h00E0;

    function automatic val_t clamp_freq(val_t f, val_t lo, val_t hi);
        if (f < lo) return lo;
        if (f > hi) return hi;
        return f;
    endfunction

    // Smallest k (0..3) with f * 2^k no longer below 8 * lo
    function automatic logic [1:0] exp_for(val_t f, val_t lo);
        logic [1:0] k;
        k = 2'd0;
        for (int i = 0; i < 3; i++) begin
            if ((f << k) < (lo << 3)) k = k + 2'd1;
        end
        return k;
    endfunction

    function automatic logic [15:0] pack_word(logic [1:0] k, idx_t m, idx_t n);
        return {8'h00, k, 6'h00} + {8'h00, m} + {n, 8'h00};
    endfunction

endpackage

// File: rtl/pds_divider.sv
module pds_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  dvs;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    assign trial = {rem, quo[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            rem  <= '0;
            quo  <= '0;
            dvs  <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                run <= 1'b1;
                cnt <= CW'(W);
                rem <= '0;
                quo <= num;
                dvs <= den;
            end else if (run) begin
                if (trial >= {1'b0, dvs}) begin
                    rem <= W'(trial - {1'b0, dvs});
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (done && dvs != '0) |-> (rem < dvs)); // R8

endmodule

// File: rtl/pds_tracker.sv
module pds_tracker
    import pds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic upd,
    input  val_t target,
    input  val_t cand,
    input  idx_t m_in,
    input  idx_t n_in,
    output idx_t best_m,
    output idx_t best_n
);
    val_t best_err;
    val_t diff;

    assign diff = (target > cand) ? (target - cand) : (cand - target);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best_err <= '1;
            best_m   <= '0;
            best_n   <= '0;
        end else if (upd && (diff < best_err)) begin
            best_err <= diff;
            best_m   <= m_in;
            best_n   <= n_in;
        end
    end

    AST_ERR_NONINC: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (best_err <= $past(best_err))); // R9

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pds_pkg::*;
#(
    parameter int M_LO    = 2,
    parameter int M_HI    = 30,
    parameter int N_LO    = 35,
    parameter int N_HI    = 247,
    parameter int F_MIN   = 8000,
    parameter int F_MAX   = 15938,
    parameter int REF_MUL = 938356,
    parameter int PS_NUM  = 100000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] period_ps,
    output logic        busy,
    output logic        done,
    output logic [15:0] word
);
    localparam idx_t M_FIRST = idx_t'(M_LO);
    localparam idx_t M_LAST  = idx_t'(M_HI);
    localparam idx_t N_FIRST = idx_t'(N_LO);
    localparam idx_t N_LAST  = idx_t'(N_HI);

    pds_state_e state;
    logic       div_go, div_done, trk_clear, trk_upd;
    val_t       div_num, div_den, div_quo, tgt, fc;
    logic [1:0] kexp;
    idx_t       m_cur, n_cur, m_nxt, n_nxt, best_m, best_n;
    logic       last_pair;

    pds_divider #(.W(32)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    assign trk_upd = (state == S_EVAL) && div_done;

    pds_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .clear  (trk_clear),
        .upd    (trk_upd),
        .target (tgt),
        .cand   (div_quo),
        .m_in   (m_cur),
        .n_in   (n_cur),
        .best_m (best_m),
        .best_n (best_n)
    );

    function automatic val_t cand_num(idx_t n);
        return val_t'(REF_MUL) * (val_t'(n) + 32'd8);
    endfunction

    function automatic val_t cand_den(idx_t m, logic [1:0] k);
        return (val_t'(m) + 32'd2) << (32'd8 + val_t'(k));
    endfunction

    assign fc        = clamp_freq(div_quo, val_t'(F_MIN), val_t'(F_MAX));
    assign last_pair = (m_cur == M_LAST) && (n_cur == N_LAST);

    always_comb begin
        if (n_cur == N_LAST) begin
            n_nxt = N_FIRST;
            m_nxt = m_cur + idx_t'(1);
        end else begin
            n_nxt = n_cur + idx_t'(1);
            m_nxt = m_cur;
        end
    end

    assign busy = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            div_go    <= 1'b0;
            div_num   <= '0;
            div_den   <= '0;
            trk_clear <= 1'b0;
            tgt       <= '0;
            kexp      <= '0;
            m_cur     <= '0;
            n_cur     <= '0;
            word      <= '0;
            done      <= 1'b0;
        end else begin
            div_go    <= 1'b0;
            done      <= 1'b0;
            trk_clear <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    div_go  <= 1'b1;
                    div_num <= val_t'(PS_NUM);
                    div_den <= period_ps;
                    state   <= S_FREQ;
                end
                S_FREQ: if (div_done) begin
                    if (div_quo == '0) begin
                        word  <= ZERO_FREQ_WORD;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        kexp    <= exp_for(fc, val_t'(F_MIN));
                        div_go  <= 1'b1;
                        div_num <= fc << 8;
                        div_den <= 32'd100;
                        state   <= S_SCALE;
                    end
                end
                S_SCALE: if (div_done) begin
                    tgt       <= div_quo;
                    m_cur     <= M_FIRST;
                    n_cur     <= N_FIRST;
                    trk_clear <= 1'b1;
                    div_go    <= 1'b1;
                    div_num   <= cand_num(N_FIRST);
                    div_den   <= cand_den(M_FIRST, kexp);
                    state     <= S_EVAL;
                end
                S_EVAL: if (div_done) begin
                    if (last_pair) begin
                        state <= S_PACK;
                    end else begin
                        m_cur   <= m_nxt;
                        n_cur   <= n_nxt;
                        div_go  <= 1'b1;
                        div_num <= cand_num(n_nxt);
                        div_den <= cand_den(m_nxt, kexp);
                    end
                end
                S_PACK: begin
                    word  <= pack_word(kexp, best_m, best_n);
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(word)); // R12
    AST_SWEEP_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (state == S_EVAL) |-> (m_cur >= M_FIRST && m_cur <= M_LAST &&
                               n_cur >= N_FIRST && n_cur <= N_LAST)); // R7

endmodule

// File: tb/pll_div_search_test.sv
module pll_div_search_test;

    localparam int ML = 2;
    localparam int MH = 7;
    localparam int NL = 35;
    localparam int NH = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] period_ps = '0;
    logic        busy, done;
    logic [15:0] word;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pll_div_search #(.M_LO(ML), .M_HI(MH), .N_LO(NL), .N_HI(NH)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .period_ps (period_ps),
        .busy      (busy),
        .done      (done),
        .word      (word)
    );

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference built from R3..R10, first minimum kept (R9)
    function automatic logic [15:0] ref_word(longint p);
        longint f, t, best, fo, d;
        int k, bm, bn;
        f = 100000000 / p;
        if (f == 0) return 16'h00E0;
        if (f < 8000) f = 8000;
        if (f > 15938) f = 15938;
        t = (f * 256) / 100;
        k = 0;
        while (f < 64000) begin
            f = f * 2;
            k++;
        end
        best = 64'hFFFFFFFF;
        bm = 0;
        bn = 0;
        for (int m = ML; m <= MH; m++) begin
            for (int n = NL; n <= NH; n++) begin
                fo = (64'd938356 * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
                d  = (t > fo) ? t - fo : fo - t;
                if (d < best) begin
                    best = d;
                    bm = m;
                    bn = n;
                end
            end
        end
        return 16'((k << 6) + bm + (bn << 8));
    endfunction

    task automatic run_search(input logic [31:0] p, output logic [15:0] w);
        int cyc;
        @(negedge clk);
        period_ps = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", busy, 1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check("R2 done reached", done, 1);
        check("R2 not busy at done", busy, 0);
        w = word;
        @(negedge clk);
        check("R2 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        check("R1 busy at reset", busy, 0);
        check("R1 done at reset", done, 0);
        check("R1 word at reset", word, 0);
    endtask

    task automatic t_in_range(input logic [31:0] p, input string tag);
        logic [15:0] w;
        run_search(p, w);
        check(tag, w, ref_word(p));
    endtask

    task automatic t_fields();
        logic [15:0] w;
        run_search(32'd7000, w);
        check("R10 word", w, ref_word(7000));
        check("R6 exponent field", w[7:6], 3);
        check("R7 M within sweep", (w[5:0] >= ML && w[5:0] <= MH), 1);
        check("R7 N within sweep", (w[15:8] >= NL && w[15:8] <= NH), 1);
    endtask

    task automatic t_zero_freq();
        logic [15:0] w;
        run_search(32'd200000000, w);
        check("R3 zero freq word", w, 16'h00E0);
        run_search(32'd100000001, w);
        check("R3 zero freq edge", w, 16'h00E0);
    endtask

    task automatic t_clamp();
        logic [15:0] a, b;
        run_search(32'd100000000, a);
        run_search(32'd12500, b);
        check("R4 low clamp equal", a, b);
        check("R4 low clamp ref", a, ref_word(12500));
        run_search(32'd4000, a);
        run_search(32'd6274, b);
        check("R4 high clamp equal", a, b);
        check("R4 high clamp ref", b, ref_word(6274));
    endtask

    task automatic t_start_busy();
        int cyc;
        @(negedge clk);
        period_ps = 32'd9000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        period_ps = 32'd5000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        period_ps = '0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check("R11 word of first request", word, ref_word(9000));
        cyc = 0;
        repeat (300) begin
            @(negedge clk);
            if (done || busy) cyc++;
        end
        check("R11 no second search", cyc, 0);
        check("R12 word held idle", word, ref_word(9000));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_in_range(32'd10000, "R8 period 10000");
        t_in_range(32'd8100, "R5 period 8100");
        t_in_range(32'd11111, "R9 period 11111");
        t_fields();
        t_zero_freq();
        t_clamp();
        t_start_busy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule